// File: doc/BRIEF.md
# NAND Hamming ECC generator

This block builds a 24-bit Hamming-style check code over a 512-byte chunk of flash data while the data moves across the flash data bus. It watches every bus beat. It folds a beat into its running code only when four things hold: the engine is enabled, the beat's chip select matches the configured one, the beat is valid, and the chunk is not yet complete. The bus may be 8 or 16 bits wide. In 16-bit mode, one beat carries two consecutive bytes, and the low byte comes first. All chip selects share a single engine.

Software arms the engine by writing a configuration word. Before each read or write pass it pulses a clear, and at the end of the pass it reads the packed 32-bit result. The parity is non-inverted, so a chunk of all-ones bytes, such as an erased page, gives a code of zero. A done flag rises when the whole chunk has been absorbed. From then on the code holds its value until the next clear.

Top module: `nand_parity_engine`

## Requirements
- R1: After reset, `result` is 0, `done` is 0 and the engine is disabled. Bus beats arriving before any configuration write leave `result` at 0.
- R2: A write on `cfg_we` loads the configuration word, with these fields: bit 0 is the enable, bits 3:1 are the chip select to watch, and bit 7 selects a 16-bit bus. All other bits of the word have no effect.
- R3: Give each data bit a 12-bit address A = {byte index[8:0], bit position[2:0]}. For every k in 0..11, `result[16+k]` is the XOR of all data bits whose A[k] is 1, and `result[k]` is the XOR of all data bits whose A[k] is 0. Bits 31:28 and 15:12 are always 0.
- R4: A full chunk of 0xFF bytes produces `result` = 0 and raises `done`.
- R5: A chunk that is zero except for one set bit at address A produces `result` = {4'h0, A, 4'h0, ~A}.
- R6: A beat whose `bus_cs` differs from the configured chip select changes neither the code nor the byte count.
- R7: After a configuration write of zero, further beats have no effect on `result` or `done`.
- R8: In 16-bit mode, `bus_data[7:0]` is byte n and `bus_data[15:8]` is byte n+1. `done` is still 0 after 255 words and is 1 after 256 words.
- R9: `done` rises when 512 bytes have been absorbed. While `done` is 1, beats do not change `result`.
- R10: A pulse on `clr` zeroes the code, the byte count and `done`. A beat in the same cycle as `clr` is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Load the configuration word |
| cfg_wdata | input | 32 | Configuration word (enable, chip select, bus width) |
| clr | input | 1 | Clear code, byte count and done |
| bus_valid | input | 1 | A data beat is present on the bus |
| bus_cs | input | 3 | Chip select of the current beat |
| bus_data | input | 16 | Beat data; only the low byte is used in 8-bit mode |
| result | output | 32 | Packed code: 0-coverage half in 11:0, 1-coverage half in 27:16 |
| done | output | 1 | Chunk complete; the code is frozen |

## Verification
The bench builds the block with its default 512-byte chunk, which gives 12-bit halves. With this size the full 9-bit byte index runs through the row parities, so the erased-page zero code and the single-bit address pattern in both halves can be observed. The 512-byte size also puts the word-count boundary at 255/256 words and the byte-count boundary at 512 bytes within reach. The expected codes come from a bit-by-bit address model in the bench.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;

    localparam int COL_BITS  = 3;
    localparam int SEL_W     = 3;
    localparam int MAX_ROW_W = 13;
    localparam int LANE_MAX  = 2;

    typedef struct packed {
        logic             wide;
        logic [SEL_W-1:0] sel;
        logic             enable;
    } ecc_cfg_t;

    typedef struct packed {
        logic [15:0] ones;
        logic [15:0] zeros;
    } ecc_pair_t;

    function automatic ecc_cfg_t decode_cfg(logic [31:0] word);
        ecc_cfg_t c;
        c.enable = word[0];
        c.sel    = word[3:1];
        c.wide   = word[7];
        return c;
    endfunction

    function automatic ecc_pair_t fold_byte(logic [7:0] d, logic [MAX_ROW_W-1:0] idx);
        ecc_pair_t r;
        logic      p;
        r = '0;
        p = ^d;
        for (int b = 0; b < 8; b++) begin
            for (int k = 0; k < COL_BITS; k++) begin
                if (b[k]) r.ones[k]  = r.ones[k]  ^ d[b];
                else      r.zeros[k] = r.zeros[k] ^ d[b];
            end
        end
        for (int k = 0; k < MAX_ROW_W; k++) begin
            if (idx[k]) r.ones[k+COL_BITS]  = r.ones[k+COL_BITS]  ^ p;
            else        r.zeros[k+COL_BITS] = r.zeros[k+COL_BITS] ^ p;
        end
        return r;
    endfunction

    function automatic ecc_pair_t pair_xor(ecc_pair_t a, ecc_pair_t b);
        ecc_pair_t r;
        r.ones  = a.ones ^ b.ones;
        r.zeros = a.zeros ^ b.zeros;
        return r;
    endfunction

endpackage

// File: rtl/nand_ecc_cfg.sv
module nand_ecc_cfg
    import nand_ecc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        we,
    input  logic [31:0] wdata,
    output ecc_cfg_t    cfg
);

    ecc_cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst)     cfg_q <= '0;
        else if (we) cfg_q <= decode_cfg(wdata);
    end

    assign cfg = cfg_q;

    p_cfg_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(cfg_q));

    p_cfg_fields_r2: assert property (@(posedge clk) disable iff (rst)
        we |=> (cfg_q.enable == $past(wdata[0])) && (cfg_q.wide == $past(wdata[7])));

endmodule

// File: rtl/nand_ecc_fold.sv
module nand_ecc_fold
    import nand_ecc_pkg::*;
#(
    parameter int ROW_W = 9
) (
    input  logic [15:0]      data,
    input  logic             wide,
    input  logic [ROW_W-1:0] base,
    output ecc_pair_t        contrib
);

    localparam int PAD_W = MAX_ROW_W - ROW_W;

    ecc_pair_t lane_c [LANE_MAX];

    for (genvar ln = 0; ln < LANE_MAX; ln++) begin : g_lane
        logic [ROW_W-1:0] lane_idx;
        logic             lane_on;
        assign lane_idx = base + ROW_W'(ln);
        assign lane_on  = (ln == 0) || wide;
        always_comb begin
            if (lane_on) lane_c[ln] = fold_byte(data[8*ln +: 8], {{PAD_W{1'b0}}, lane_idx});
            else         lane_c[ln] = '0;
        end
    end

    always_comb begin
        contrib = '0;
        for (int ln = 0; ln < LANE_MAX; ln++) contrib = pair_xor(contrib, lane_c[ln]);
    end

endmodule

// File: rtl/nand_ecc_accum.sv
module nand_ecc_accum
    import nand_ecc_pkg::*;
#(
    parameter int CHUNK_BYTES = 512
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             beat_valid,
    input  logic [SEL_W-1:0] beat_cs,
    input  logic [15:0]      beat_data,
    input  ecc_cfg_t         cfg,
    output ecc_pair_t        acc,
    output logic             done
);

    localparam int ROW_W  = $clog2(CHUNK_BYTES);
    localparam int HALF_W = COL_BITS + ROW_W;
    localparam int CNT_W  = ROW_W + 1;
    localparam logic [15:0] HALF_MASK = 16'((32'd1 << HALF_W) - 1);
    localparam logic [CNT_W-1:0] CHUNK_C = CNT_W'(CHUNK_BYTES);

    ecc_pair_t        acc_q;
    logic [CNT_W-1:0] count_q;
    logic             done_q;
    ecc_pair_t        contrib;
    logic             hit;
    logic [CNT_W-1:0] step;
    logic [CNT_W-1:0] next_count;

    nand_ecc_fold #(.ROW_W(ROW_W)) u_fold (
        .data    (beat_data),
        .wide    (cfg.wide),
        .base    (count_q[ROW_W-1:0]),
        .contrib (contrib)
    );

    assign hit        = beat_valid && cfg.enable && (beat_cs == cfg.sel) && !done_q;
    assign step       = cfg.wide ? CNT_W'(2) : CNT_W'(1);
    assign next_count = count_q + step;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            acc_q   <= '0;
            count_q <= '0;
            done_q  <= 1'b0;
        end else if (hit) begin
            acc_q.ones  <= acc_q.ones  ^ (contrib.ones  & HALF_MASK);
            acc_q.zeros <= acc_q.zeros ^ (contrib.zeros & HALF_MASK);
            count_q     <= next_count;
            if (next_count >= CHUNK_C) done_q <= 1'b1;
        end
    end

    assign acc  = acc_q;
    assign done = done_q;

    p_frozen_done_r9: assert property (@(posedge clk) disable iff (rst)
        done_q && !clr |=> $stable(acc_q) && done_q);

    p_count_bound_r9: assert property (@(posedge clk) disable iff (rst)
        count_q <= CHUNK_C);

    p_foreign_cs_r6: assert property (@(posedge clk) disable iff (rst)
        beat_valid && (beat_cs != cfg.sel) && !clr |=> $stable(acc_q) && $stable(count_q));

    p_disabled_r7: assert property (@(posedge clk) disable iff (rst)
        !cfg.enable && !clr |=> $stable(acc_q) && $stable(count_q));

    p_clear_r10: assert property (@(posedge clk) disable iff (rst)
        clr |=> (acc_q == '0) && (count_q == '0) && !done_q);

endmodule

// File: rtl/nand_parity_engine.sv
module nand_parity_engine
    import nand_ecc_pkg::*;
#(
    parameter int CHUNK_BYTES = 512
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_we,
    input  logic [31:0] cfg_wdata,
    input  logic        clr,
    input  logic        bus_valid,
    input  logic [2:0]  bus_cs,
    input  logic [15:0] bus_data,
    output logic [31:0] result,
    output logic        done
);

    localparam int HALF_W   = COL_BITS + $clog2(CHUNK_BYTES);
    localparam int HI_LSB   = 16;

    ecc_cfg_t  cfg;
    ecc_pair_t acc;

    nand_ecc_cfg u_cfg (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .cfg   (cfg)
    );

    nand_ecc_accum #(.CHUNK_BYTES(CHUNK_BYTES)) u_accum (
        .clk        (clk),
        .rst        (rst),
        .clr        (clr),
        .beat_valid (bus_valid),
        .beat_cs    (bus_cs),
        .beat_data  (bus_data),
        .cfg        (cfg),
        .acc        (acc),
        .done       (done)
    );

    always_comb begin
        result = '0;
        result[HALF_W-1:0]               = acc.zeros[HALF_W-1:0];
        result[HI_LSB+HALF_W-1:HI_LSB]   = acc.ones[HALF_W-1:0];
    end

    initial begin
        p_half_fits_r3: assert (HALF_W <= HI_LSB);
    end

    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> (result == '0) && !done);

endmodule

// File: tb/test_nand_parity_engine.sv
module test_nand_parity_engine;

    localparam int CLK_PERIOD = 10;
    localparam int NBYTES     = 512;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we;
    logic [31:0] cfg_wdata;
    logic        clr;
    logic        bus_valid;
    logic [2:0]  bus_cs;
    logic [15:0] bus_data;
    logic [31:0] result;
    logic        done;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    logic [7:0] mem [NBYTES];

    always #(CLK_PERIOD/2) clk = ~clk;

    nand_parity_engine i_nand_parity_engine (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .clr       (clr),
        .bus_valid (bus_valid),
        .bus_cs    (bus_cs),
        .bus_data  (bus_data),
        .result    (result),
        .done      (done)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%08h expected=%08h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_code(input int n);
        logic [11:0] ones, zeros, a;
        ones = '0; zeros = '0;
        for (int i = 0; i < n; i++) begin
            for (int b = 0; b < 8; b++) begin
                if (mem[i][b]) begin
                    a = {i[8:0], b[2:0]};
                    for (int k = 0; k < 12; k++) begin
                        if (a[k]) ones[k] = ~ones[k];
                        else      zeros[k] = ~zeros[k];
                    end
                end
            end
        end
        return {4'h0, ones, 4'h0, zeros};
    endfunction

    task automatic write_cfg(input logic [31:0] v);
        @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk); cfg_we = 1'b0; cfg_wdata = '0;
    endtask

    task automatic pulse_clr();
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
    endtask

    task automatic beat(input logic [2:0] cs, input logic [15:0] d);
        @(negedge clk); bus_valid = 1'b1; bus_cs = cs; bus_data = d;
        @(negedge clk); bus_valid = 1'b0; bus_data = '0;
    endtask

    task automatic feed8(input logic [2:0] cs, input int first, input int last);
        for (int i = first; i < last; i++) beat(cs, {8'h00, mem[i]});
    endtask

    task automatic t_reset();
        rst = 1'b1; cfg_we = 0; cfg_wdata = '0; clr = 0;
        bus_valid = 0; bus_cs = '0; bus_data = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        check("R1", "result after reset", result, 32'h0);
        check("R1", "done after reset", {31'h0, done}, 32'h0);
        beat(3'd0, 16'h00A7);
        check("R1", "beat before config ignored", result, 32'h0);
    endtask

    task automatic t_erased();
        for (int i = 0; i < NBYTES; i++) mem[i] = 8'hFF;
        write_cfg(32'h0000_0005);
        pulse_clr();
        feed8(3'd2, 0, NBYTES);
        check("R4", "erased chunk code", result, 32'h0);
        check("R4", "erased chunk done", {31'h0, done}, 32'h1);
    endtask

    task automatic t_single_bit();
        logic [11:0] a;
        for (int i = 0; i < NBYTES; i++) mem[i] = 8'h00;
        mem[300] = 8'h20;
        a = {9'd300, 3'd5};
        write_cfg(32'hFFFF_FF71);
        pulse_clr();
        feed8(3'd0, 0, NBYTES);
        check("R5", "single bit pattern", result, {4'h0, a, 4'h0, ~a});
        check("R2", "reserved cfg bits ignored, done", {31'h0, done}, 32'h1);
    endtask

    task automatic t_foreign_cs();
        for (int i = 0; i < NBYTES; i++) mem[i] = 8'((i * 37 + 11) & 8'hFF);
        write_cfg(32'h0000_000B);
        pulse_clr();
        for (int i = 0; i < NBYTES; i++) begin
            if (i % 7 == 3) beat(3'd3, 16'h5AA5);
            beat(3'd5, {8'h00, mem[i]});
        end
        check("R3", "pattern code 8-bit", result, ref_code(NBYTES));
        check("R6", "foreign cs ignored, done", {31'h0, done}, 32'h1);
    endtask

    task automatic t_wide();
        for (int i = 0; i < NBYTES; i++) mem[i] = 8'((i * 91 + 5) ^ (i >> 3));
        write_cfg(32'h0000_0083);
        pulse_clr();
        for (int w = 0; w < 255; w++) beat(3'd1, {mem[2*w+1], mem[2*w]});
        check("R8", "done low after 255 words", {31'h0, done}, 32'h0);
        check("R8", "partial wide code", result, ref_code(510));
        beat(3'd1, {mem[511], mem[510]});
        check("R8", "done after 256 words", {31'h0, done}, 32'h1);
        check("R8", "wide code", result, ref_code(NBYTES));
    endtask

    task automatic t_after_done();
        logic [31:0] held;
        held = result;
        beat(3'd1, 16'hFFFF);
        beat(3'd1, 16'h1234);
        check("R9", "code frozen after done", result, held);
        check("R9", "done held", {31'h0, done}, 32'h1);
    endtask

    task automatic t_stop_clear();
        for (int i = 0; i < NBYTES; i++) mem[i] = 8'((i * 13 + 200) & 8'hFF);
        write_cfg(32'h0000_0001);
        pulse_clr();
        feed8(3'd0, 0, 100);
        write_cfg(32'h0000_0000);
        feed8(3'd0, 100, 150);
        check("R7", "stopped code", result, ref_code(100));
        check("R7", "stopped done", {31'h0, done}, 32'h0);
        pulse_clr();
        check("R10", "clear zeroes code", result, 32'h0);
    endtask

    task automatic t_clear_priority();
        for (int i = 0; i < NBYTES; i++) mem[i] = 8'h00;
        write_cfg(32'h0000_0001);
        feed8(3'd0, 0, 10);
        @(negedge clk); clr = 1'b1; bus_valid = 1'b1; bus_cs = 3'd0; bus_data = 16'h0080;
        @(negedge clk); clr = 1'b0; bus_valid = 1'b0; bus_data = '0;
        check("R10", "beat with clear discarded", result, 32'h0);
        mem[0] = 8'h01;
        beat(3'd0, 16'h0001);
        check("R10", "count restarts at byte 0", result, ref_code(1));
    endtask

    initial begin
        t_reset();
        t_erased();
        t_single_bit();
        t_foreign_cs();
        t_wide();
        t_after_done();
        t_stop_clear();
        t_clear_priority();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule